// File: doc/BRIEF.md
# Sample Data Packet Assembler

This block turns one block of captured one-byte samples into a complete reply packet and offers that packet one byte at a time on a valid/ready stream. The packet has three sections. A 7-byte header ends in an 8-bit header checksum. An 11-byte fixed section carries the packet sequence number, the sample-rate setting, the sample width and the sample count. A variable section holds N samples (1 to 512) and ends in a 16-bit payload checksum. A packet is therefore 20 + N bytes long, and never longer than 532 bytes.

A start pulse with a sample count launches one packet. The samples are fetched through an address port that is shared by the two channel read ports. When both channels are enabled, successive packets take turns between channel 0 and channel 1. A pending-command flag never cuts a packet short. It only prevents a new packet from starting, so the controller above can serve its command once the block reports idle.

Top module: `sdpkt_builder`

## Requirements
- R1: A start pulse is accepted only when all of these hold: idle_o is high, cmd_pend_i is low, count_i is in 1..512, and at least one chan_en_i bit is set. Any other start pulse is ignored: no byte is offered and idle_o stays high.
- R2: An accepted packet is exactly 20 + N bytes. done_o is high for exactly one cycle, the cycle after the last byte is accepted, and idle_o is high from that cycle on.
- R3: The header bytes, in stream order, are as follows. Byte 0 is 0x5A. Byte 1 is 0x53. Byte 2 is the channel number (0 or 1). Bytes 3 and 4 hold the payload length 13 + N, most significant byte first. Byte 5 is 0x00. Byte 6 is the low 8 bits of the sum of bytes 0 to 5.
- R4: Bytes 7 to 17 are as follows. Bytes 7 to 10 hold the 32-bit packet number, most significant byte first. Bytes 11 to 14 hold rate_i as sampled at the accepted start, most significant byte first. Byte 15 is 0x08. Bytes 16 and 17 hold N as 16 bits, most significant byte first.
- R5: Bytes 18 to 17 + N are the samples of the packet's channel at addresses 0 to N - 1, in that order. The final two bytes hold the low 16 bits of the sum of bytes 7 to 17 + N, most significant byte first.
- R6: The packet number is 0 for the first packet after reset and increases by one after every completed packet.
- R7: With one channel enabled, that channel is sent. With both enabled, a packet uses the channel opposite to the previous packet's channel, and the first packet after reset uses channel 0.
- R8: Raising cmd_pend_i during a packet neither shortens nor alters it. After that packet the block stays idle for as long as cmd_pend_i is high.
- R9: While tx_valid_o is high and tx_ready_i is low, tx_valid_o and tx_data_o hold their values into the next cycle.
- R10: After reset, idle_o is high and tx_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request one packet |
| count_i | input | 10 | Samples in the requested packet (1..512) |
| chan_en_i | input | 2 | Channel enable bits |
| rate_i | input | 32 | Current sample-rate setting |
| cmd_pend_i | input | 1 | A command is waiting |
| rd_addr_o | output | 9 | Sample address shared by both channel read ports |
| rd_data0_i | input | 8 | Channel 0 sample at rd_addr_o (same cycle) |
| rd_data1_i | input | 8 | Channel 1 sample at rd_addr_o (same cycle) |
| tx_data_o | output | 8 | Packet byte |
| tx_valid_o | output | 1 | tx_data_o holds a byte |
| tx_ready_i | input | 1 | Sink takes the byte |
| done_o | output | 1 | One-cycle pulse after the last byte |
| idle_o | output | 1 | No packet in flight |
| chan_o | output | 1 | Channel of the current or last packet |

## Verification
A wrong byte index or a wrong section boundary shows up on the very next accepted byte as a misplaced field. The whole packet then also has the wrong length, which appears at done_o. A corrupted checksum accumulator stays hidden until the final two bytes, so the bench compares every byte of every packet against a model and not only the checksums. A wrong alternation or sequence register surfaces only on the following packet, at byte 2 or at bytes 7 to 10, which is why packets are sent back to back under changing enable patterns.

// File: rtl/sdpkt_pkg.sv
package sdpkt_pkg;

    localparam int unsigned HDR_BYTES = 7;
    localparam int unsigned FIX_BYTES = 11;
    localparam int unsigned CKS_BYTES = 2;
    localparam int unsigned SMP_MAX   = 512;
    localparam int unsigned PKT_MAX   = HDR_BYTES + FIX_BYTES + SMP_MAX + CKS_BYTES;
    localparam int unsigned FIX_BASE  = HDR_BYTES;
    localparam int unsigned SMP_BASE  = HDR_BYTES + FIX_BYTES;

    localparam int unsigned IDX_W  = $clog2(PKT_MAX + 1);
    localparam int unsigned CNT_W  = $clog2(SMP_MAX + 1);
    localparam int unsigned ADDR_W = $clog2(SMP_MAX);
    localparam int unsigned SEQ_W  = 32;
    localparam int unsigned RATE_W = 32;
    localparam int unsigned SUM_W  = 16;

    localparam logic [7:0] SYNC_BYTE    = 8'h5A;
    localparam logic [7:0] KIND_SAMPLES = 8'h53;
    localparam logic [7:0] SAMPLE_BITS  = 8'd8;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

    typedef struct packed {
        logic              ch;
        logic [CNT_W-1:0]  cnt;
        logic [RATE_W-1:0] rate;
        logic [SEQ_W-1:0]  seq;
    } pkt_ctx_t;

    function automatic logic [15:0] payload_len(input logic [CNT_W-1:0] cnt);
        return 16'(FIX_BYTES + CKS_BYTES) + 16'(cnt);
    endfunction

    // header bytes 0..5; byte 6 is the checksum, produced by hdr_sum
    function automatic logic [7:0] hdr_byte(input pkt_ctx_t c, input logic [3:0] i);
        logic [15:0] len;
        len = payload_len(c.cnt);
        case (i)
            4'd0:    return SYNC_BYTE;
            4'd1:    return KIND_SAMPLES;
            4'd2:    return {7'd0, c.ch};
            4'd3:    return len[15:8];
            4'd4:    return len[7:0];
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] hdr_sum(input pkt_ctx_t c);
        logic [15:0] s;
        s = '0;
        for (int i = 0; i < HDR_BYTES - 1; i++) begin
            s = s + 16'(hdr_byte(c, 4'(i)));
        end
        return s[7:0];
    endfunction

    function automatic logic [7:0] fix_byte(input pkt_ctx_t c, input logic [3:0] j);
        logic [15:0] n16;
        n16 = 16'(c.cnt);
        case (j)
            4'd0:    return c.seq[31:24];
            4'd1:    return c.seq[23:16];
            4'd2:    return c.seq[15:8];
            4'd3:    return c.seq[7:0];
            4'd4:    return c.rate[31:24];
            4'd5:    return c.rate[23:16];
            4'd6:    return c.rate[15:8];
            4'd7:    return c.rate[7:0];
            4'd8:    return SAMPLE_BITS;
            4'd9:    return n16[15:8];
            default: return n16[7:0];
        endcase
    endfunction

endpackage

// File: rtl/sdpkt_chsel.sv
module sdpkt_chsel (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] en_i,
    input  logic       take_i,
    output logic       ch_o
);
    logic last_q;

    always_comb begin
        case (en_i)
            2'b01:   ch_o = 1'b0;
            2'b10:   ch_o = 1'b1;
            default: ch_o = ~last_q;
        endcase
    end

    // last_q resets to 1 so that the first shared packet goes to channel 0
    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= 1'b1;
        end else if (take_i) begin
            last_q <= ch_o;
        end
    end
endmodule

// File: rtl/sdpkt_cksum.sv
module sdpkt_cksum #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         add_i,
    input  logic [7:0]   byte_i,
    output logic [W-1:0] sum_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            sum_o <= '0;
        end else if (add_i) begin
            sum_o <= sum_o + W'(byte_i);
        end
    end
endmodule

// File: rtl/sdpkt_seq.sv
module sdpkt_seq
    import sdpkt_pkg::*;
#(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go_i,
    input  logic         fire_i,
    input  logic [W-1:0] last_i,
    output logic         busy_o,
    output logic         wrap_o,
    output logic [W-1:0] idx_o,
    output logic         done_o
);
    phase_e ph_q;

    assign busy_o = (ph_q == PH_SEND);
    assign wrap_o = busy_o && fire_i && (idx_o == last_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            idx_o  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            case (ph_q)
                PH_IDLE: begin
                    if (go_i) begin
                        ph_q  <= PH_SEND;
                        idx_o <= '0;
                    end
                end
                default: begin
                    if (wrap_o) begin
                        ph_q   <= PH_IDLE;
                        done_o <= 1'b1;
                    end else if (fire_i) begin
                        idx_o <= idx_o + W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/sdpkt_builder.sv
module sdpkt_builder
    import sdpkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [1:0]        chan_en_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              cmd_pend_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [7:0]        rd_data0_i,
    input  logic [7:0]        rd_data1_i,
    output logic [7:0]        tx_data_o,
    output logic              tx_valid_o,
    input  logic              tx_ready_i,
    output logic              done_o,
    output logic              idle_o,
    output logic              chan_o
);
    localparam logic [IDX_W-1:0] HCK_IDX = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] FIX_IDX = IDX_W'(FIX_BASE);
    localparam logic [IDX_W-1:0] SMP_IDX = IDX_W'(SMP_BASE);

    pkt_ctx_t          ctx_q;
    logic [SEQ_W-1:0]  seq_q;
    logic              busy, wrap, fire, go, ch_next, cnt_ok;
    logic [IDX_W-1:0]  idx, smp_end, last_idx, fix_off, smp_off;
    logic [SUM_W-1:0]  psum;
    logic              in_smp, in_pay;

    assign cnt_ok = (count_i != '0) && (count_i <= CNT_W'(SMP_MAX));
    assign go     = start_i && !busy && !cmd_pend_i && (chan_en_i != 2'b00) && cnt_ok;
    assign fire   = busy && tx_ready_i;

    assign smp_end  = SMP_IDX + IDX_W'(ctx_q.cnt);
    assign last_idx = smp_end + IDX_W'(1);
    assign fix_off  = idx - FIX_IDX;
    assign smp_off  = idx - SMP_IDX;
    assign in_smp   = (idx >= SMP_IDX) && (idx < smp_end);
    assign in_pay   = (idx >= FIX_IDX) && (idx < smp_end);

    sdpkt_chsel chsel_i (
        .clk    (clk),
        .rst    (rst),
        .en_i   (chan_en_i),
        .take_i (go),
        .ch_o   (ch_next)
    );

    sdpkt_seq #(.W(IDX_W)) seq_i (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go),
        .fire_i (fire),
        .last_i (last_idx),
        .busy_o (busy),
        .wrap_o (wrap),
        .idx_o  (idx),
        .done_o (done_o)
    );

    sdpkt_cksum #(.W(SUM_W)) cksum_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (go),
        .add_i  (fire && in_pay),
        .byte_i (tx_data_o),
        .sum_o  (psum)
    );

    // packet context is frozen at the accepted start; the number advances on the last byte
    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
            seq_q <= '0;
        end else begin
            if (go) begin
                ctx_q.ch   <= ch_next;
                ctx_q.cnt  <= count_i;
                ctx_q.rate <= rate_i;
                ctx_q.seq  <= seq_q;
            end
            if (wrap) begin
                seq_q <= seq_q + SEQ_W'(1);
            end
        end
    end

    always_comb begin
        if (idx < HCK_IDX) begin
            tx_data_o = hdr_byte(ctx_q, idx[3:0]);
        end else if (idx == HCK_IDX) begin
            tx_data_o = hdr_sum(ctx_q);
        end else if (idx < SMP_IDX) begin
            tx_data_o = fix_byte(ctx_q, fix_off[3:0]);
        end else if (in_smp) begin
            tx_data_o = ctx_q.ch ? rd_data1_i : rd_data0_i;
        end else if (idx == smp_end) begin
            tx_data_o = psum[15:8];
        end else begin
            tx_data_o = psum[7:0];
        end
    end

    assign rd_addr_o  = in_smp ? smp_off[ADDR_W-1:0] : '0;
    assign tx_valid_o = busy;
    assign idle_o     = !busy;
    assign chan_o     = ctx_q.ch;
endmodule

// File: rtl/sdpkt_builder_chk.sv
module sdpkt_builder_chk
    import sdpkt_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [CNT_W-1:0] count_i,
    input logic [1:0]       chan_en_i,
    input logic [7:0]       tx_data_o,
    input logic             tx_valid_o,
    input logic             tx_ready_i,
    input logic             done_o,
    input logic             idle_o
);
    a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    a_r8_no_abort: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o |=> (tx_valid_o || done_o));

    a_r2_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r2_done_idle: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (idle_o && !tx_valid_o));

    a_r1_no_channel: assert property (@(posedge clk) disable iff (rst)
        (idle_o && start_i && chan_en_i == 2'b00) |=> idle_o);

    a_r1_zero_count: assert property (@(posedge clk) disable iff (rst)
        (idle_o && start_i && count_i == '0) |=> idle_o);
endmodule

bind sdpkt_builder sdpkt_builder_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .count_i    (count_i),
    .chan_en_i  (chan_en_i),
    .tx_data_o  (tx_data_o),
    .tx_valid_o (tx_valid_o),
    .tx_ready_i (tx_ready_i),
    .done_o     (done_o),
    .idle_o     (idle_o)
);

// File: tb/sdpkt_builder_tb_top.sv
module sdpkt_builder_tb_top;
    import sdpkt_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  count = '0;
    logic [1:0]        chan_en = 2'b00;
    logic [RATE_W-1:0] rate_in = '0;
    logic              cmd_pend = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data0, rd_data1, tx_data;
    logic              tx_valid, tx_ready = 1'b0, done, idle, chan;

    always #10 clk = ~clk;

    function automatic logic [7:0] smp0(input logic [ADDR_W-1:0] a);
        return a[7:0] ^ 8'h3C;
    endfunction
    function automatic logic [7:0] smp1(input logic [ADDR_W-1:0] a);
        logic [15:0] t;
        t = 16'(a) * 16'd5 + 16'd17;
        return t[7:0];
    endfunction

    assign rd_data0 = smp0(rd_addr);
    assign rd_data1 = smp1(rd_addr);

    sdpkt_builder dut_i (
        .clk(clk), .rst(rst), .start_i(start), .count_i(count), .chan_en_i(chan_en),
        .rate_i(rate_in), .cmd_pend_i(cmd_pend), .rd_addr_o(rd_addr),
        .rd_data0_i(rd_data0), .rd_data1_i(rd_data1), .tx_data_o(tx_data),
        .tx_valid_o(tx_valid), .tx_ready_i(tx_ready), .done_o(done),
        .idle_o(idle), .chan_o(chan)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog (all requirements): got %0d cycles expected below 150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, expv);
        end
    endtask

    // reference model state
    int  m_seq = 0;
    bit  m_last = 1'b1;
    int  exp_b[532];
    int  got_b[600];
    logic [7:0] lf = 8'hA7;

    function automatic void build(input bit ch, input int n, input logic [31:0] rate, input int seq);
        int s;
        logic [31:0] q;
        q = 32'(seq);
        exp_b[0] = 'h5A; exp_b[1] = 'h53; exp_b[2] = int'(ch);
        exp_b[3] = ((13 + n) >> 8) & 255; exp_b[4] = (13 + n) & 255; exp_b[5] = 0;
        s = 0;
        for (int i = 0; i < 6; i++) s += exp_b[i];
        exp_b[6] = s & 255;
        exp_b[7] = int'(q[31:24]); exp_b[8] = int'(q[23:16]);
        exp_b[9] = int'(q[15:8]);  exp_b[10] = int'(q[7:0]);
        exp_b[11] = int'(rate[31:24]); exp_b[12] = int'(rate[23:16]);
        exp_b[13] = int'(rate[15:8]);  exp_b[14] = int'(rate[7:0]);
        exp_b[15] = 8; exp_b[16] = (n >> 8) & 255; exp_b[17] = n & 255;
        for (int i = 0; i < n; i++)
            exp_b[18 + i] = ch ? int'(smp1(ADDR_W'(i))) : int'(smp0(ADDR_W'(i)));
        s = 0;
        for (int i = 7; i < 18 + n; i++) s += exp_b[i];
        exp_b[18 + n] = (s >> 8) & 255;
        exp_b[19 + n] = s & 255;
    endfunction

    task automatic sect(input int lo, input int hi, input int k, input string req, input string what);
        int bad;
        int fa, fe;
        bad = 0; fa = 0; fe = 0;
        for (int i = lo; i <= hi; i++) begin
            if (i >= k || got_b[i] != exp_b[i]) begin
                if (bad == 0) begin fa = (i < k) ? got_b[i] : -1; fe = exp_b[i]; end
                bad++;
            end
        end
        chk(bad == 0, req, what, fa, fe);
    endtask

    task automatic run_pkt(input logic [1:0] en, input int n, input logic [31:0] rate,
                           input int mode, input int cmd_at, input int busy_at, input string tag);
        bit ch, stall, inj;
        int k, loops, hold_err;
        logic [7:0] pd;
        ch = (en == 2'b01) ? 1'b0 : (en == 2'b10) ? 1'b1 : ~m_last;
        build(ch, n, rate, m_seq);
        chan_en = en; count = CNT_W'(n); rate_in = rate; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0; loops = 0; stall = 0; hold_err = 0; inj = 0; pd = '0;
        while (!done && loops < 3000) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            case (mode)
                0: tx_ready = 1'b1;
                1: tx_ready = lf[0];
                default: tx_ready = (loops % 3) == 0;
            endcase
            if (stall && tx_valid && tx_data !== pd) hold_err++;
            if (tx_valid && tx_ready) begin
                if (k < 600) got_b[k] = int'(tx_data);
                k++;
                if (k == cmd_at) cmd_pend = 1'b1;
            end
            stall = tx_valid && !tx_ready;
            pd = tx_data;
            if (busy_at >= 0 && k == busy_at && !inj) begin
                start = 1'b1; count = CNT_W'(2); rate_in = ~rate; inj = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            loops++;
        end
        tx_ready = 1'b0;
        start = 1'b0;
        $display("packet %s: ch %0d n %0d bytes %0d", tag, ch, n, k);
        chk(done === 1'b1, "R2", "done after last byte", longint'(done), 1);
        chk(idle === 1'b1 && tx_valid === 1'b0, "R2", "idle after packet", longint'(idle), 1);
        chk(k == 20 + n, "R2", "packet length", k, 20 + n);
        sect(0, 6, k, "R3", "header bytes");
        sect(2, 2, k, "R7", "channel byte");
        sect(7, 10, k, "R6", "packet number");
        sect(11, 17, k, "R4", "fixed payload");
        sect(18, 19 + n, k, "R5", "samples and payload checksum");
        chk(hold_err == 0, "R9", "stalled byte held", hold_err, 0);
        @(negedge clk);
        chk(done === 1'b0, "R2", "done one cycle", longint'(done), 0);
        m_last = ch;
        m_seq++;
    endtask

    task automatic expect_ignored(input logic [1:0] en, input int n, input string req, input string what);
        int seen;
        chan_en = en; count = CNT_W'(n); rate_in = 32'h0BAD_F00D; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        seen = 0;
        repeat (6) begin
            if (tx_valid || !idle) seen++;
            @(negedge clk);
        end
        chk(seen == 0, req, what, seen, 0);
    endtask

    // {enables, count, rate, ready pattern}
    localparam int NV = 7;
    localparam logic [45:0] VEC [NV] = '{
        {2'b01, 10'd1,   32'h0000_0001, 2'd0},
        {2'b10, 10'd5,   32'h1234_5678, 2'd1},
        {2'b11, 10'd16,  32'hDEAD_BEEF, 2'd2},
        {2'b11, 10'd3,   32'h0000_0100, 2'd1},
        {2'b11, 10'd512, 32'hFFFF_FFFF, 2'd0},
        {2'b01, 10'd200, 32'h00C0_FFEE, 2'd1},
        {2'b11, 10'd7,   32'h8000_0000, 2'd2}
    };

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(idle === 1'b1 && tx_valid === 1'b0 && done === 1'b0, "R10", "reset state",
            longint'({idle, tx_valid, done}), 4);

        for (int v = 0; v < NV; v++) begin
            run_pkt(VEC[v][45:44], int'(VEC[v][43:34]), VEC[v][33:2], int'(VEC[v][1:0]), -1, -1, "table");
        end

        // R1: starts that must be ignored
        expect_ignored(2'b00, 10, "R1", "no channel enabled");
        expect_ignored(2'b11, 0, "R1", "zero count");
        expect_ignored(2'b11, 513, "R1", "count above 512");
        cmd_pend = 1'b1;
        expect_ignored(2'b01, 4, "R1", "command pending at start");
        cmd_pend = 1'b0;

        // R8: command arrives mid-packet; packet completes, then block stays idle
        run_pkt(2'b11, 40, 32'hA5A5_0001, 1, 10, -1, "command mid-packet");
        expect_ignored(2'b11, 4, "R8", "idle while command pending");
        cmd_pend = 1'b0;

        // R1: start during a packet is ignored, even with changed rate and count
        run_pkt(2'b10, 9, 32'h0102_0304, 0, -1, 3, "start while busy");
        expect_ignored(2'b00, 4, "R1", "no packet after busy start");

        // R7: alternation continues correctly after ignored starts
        run_pkt(2'b11, 2, 32'h0000_0042, 0, -1, -1, "alternation resume");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule